// File: doc/BRIEF.md
# CAN Mailbox Status and Interrupt Unit

This unit holds the per-mailbox status flags and the mailbox-related interrupt-request flags of a 32-mailbox CAN controller. The protocol engine reports five kinds of one-cycle events, each with its own strobe and mailbox index: data frame received, remote frame received, overrun/overwrite, transmission completed and transmission aborted. Software reaches the flags through a 16-bit register port. Every 32-bit per-mailbox register is seen as two 16-bit halves.

A per-mailbox mask register decides only whether an event raises an interrupt-request bit. Status flags are updated no matter what the mask holds. The four implemented interrupt-request bits are sticky and are cleared by writing 1. Their OR drives a single interrupt line. Message storage, acceptance filtering and the protocol engine live elsewhere.

Top module: `can_mbox_status`

## Requirements
- R1: Address `wr_addr`/`rd_addr` = {register code[3:0], half select}. Half select 0 maps data bit n to mailbox n. Half select 1 maps bit n to mailbox 16+n. Codes: 0 transmit-pending, 1 transmit-cancel, 2 transmit-acknowledge, 3 abort-acknowledge, 4 receive-pending, 5 remote-pending, 6 unread-message, 7 interrupt mask, 8 interrupt-request flags (half 0 only).
- R2: A remote-frame event sets the remote-pending bit of its mailbox. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R3: A data-frame event sets the receive-pending bit of its mailbox, and an overrun event sets its unread-message bit. Both are cleared by writing 1, and writing 0 has no effect.
- R4: When a mailbox's mask bit is 1, its data, remote and overrun events do not set interrupt-request bits 1, 2 and 9, but the status bits of R2/R3 still set. The mask value used is the one held before the event's clock edge.
- R5: A transmission-complete event clears the mailbox's transmit-pending and transmit-cancel bits and sets its transmit-acknowledge bit, whatever the mask holds. It sets interrupt-request bit 8 only when the mailbox is unmasked.
- R6: A transmission-abort event clears the mailbox's transmit-pending and transmit-cancel bits and sets its abort-acknowledge bit, whatever the mask holds. It sets interrupt-request bit 8 only when the mailbox is unmasked.
- R7: Writing 1 to a transmit-pending or transmit-cancel bit sets it, and writing 0 leaves it unchanged.
- R8: When a set and a clear reach the same bit in the same cycle, the bit ends up 1. For the event flags this means a hardware event beats a software write-1 clear. For pending/cancel it means a software write-1 set beats a hardware clear.
- R9: Interrupt-request bits 1, 2, 8 and 9 stay set until written with 1. Clearing a mask bit does not raise a bit for an event that was masked earlier. All other interrupt-request bits read 0.
- R10: `irq_o` is 1 exactly when some interrupt-request bit is 1.
- R11: A synchronous active-high reset brings every register to 0.
- R12: The mask register is plain read/write per half. Reads of codes 9 to 15, or of code 8 half 1, return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_rxdata | input | 1 | Data frame stored in a mailbox |
| ev_rxdata_mb | input | 5 | Mailbox of the data frame event |
| ev_remote | input | 1 | Remote frame stored in a mailbox |
| ev_remote_mb | input | 5 | Mailbox of the remote frame event |
| ev_overrun | input | 1 | Overrun/overwrite in a mailbox |
| ev_overrun_mb | input | 5 | Mailbox of the overrun event |
| ev_txdone | input | 1 | Transmission completed |
| ev_txdone_mb | input | 5 | Mailbox of the completed transmission |
| ev_txabort | input | 1 | Transmission aborted |
| ev_txabort_mb | input | 5 | Mailbox of the aborted transmission |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address (R1) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 5 | Read address (R1), combinational read |
| rd_data | output | 16 | Read data |
| irq_flags | output | 16 | Interrupt-request flags |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The bench uses the default parameters: 32 mailboxes in 16-bit halves. Both halves and the boundary between mailbox 15 and mailbox 16 can therefore be reached through the register port. Mailbox indices are biased toward 0, 15, 16 and 31, so that events land on both edges of both halves. Random writes cover all sixteen codes, including the unused ones. This brings same-cycle event/write collisions and masked events within reach, and every register is compared after every cycle.

// File: rtl/can_mbox_status_pkg.sv
package can_mbox_status_pkg;

  typedef enum logic [1:0] {
    FLAG_SW_SET = 2'd0,
    FLAG_HW_SET = 2'd1,
    FLAG_PLAIN  = 2'd2
  } flag_kind_e;

  localparam int unsigned CODE_W     = 4;
  localparam int unsigned NUM_BANKS  = 8;
  localparam int unsigned C_TXPEND   = 0;
  localparam int unsigned C_TXCAN    = 1;
  localparam int unsigned C_TXACK    = 2;
  localparam int unsigned C_ABACK    = 3;
  localparam int unsigned C_RXPEND   = 4;
  localparam int unsigned C_RMTPEND  = 5;
  localparam int unsigned C_UNREAD   = 6;
  localparam int unsigned C_MASK     = 7;
  localparam int unsigned C_IRQ      = 8;

  localparam int unsigned IRQ_W      = 16;
  localparam int unsigned IRQ_RXDATA = 1;
  localparam int unsigned IRQ_RMT    = 2;
  localparam int unsigned IRQ_EMPTY  = 8;
  localparam int unsigned IRQ_OVR    = 9;
  localparam logic [IRQ_W-1:0] IRQ_IMPL = 16'h0306;

  // Which write behaviour a flag bank has, by register code
  function automatic flag_kind_e kind_of(int unsigned code);
    if (code == C_TXPEND || code == C_TXCAN) return FLAG_SW_SET;
    if (code == C_MASK) return FLAG_PLAIN;
    return FLAG_HW_SET;
  endfunction

endpackage

// File: rtl/can_mbox_flag_bank.sv
module can_mbox_flag_bank
  import can_mbox_status_pkg::*;
#(
  parameter int unsigned NUM_MB = 32,
  parameter int unsigned HALF_W = 16,
  parameter flag_kind_e  KIND   = FLAG_HW_SET,
  localparam int unsigned HALVES = NUM_MB / HALF_W,
  localparam int unsigned SEL_W  = (HALVES > 1) ? $clog2(HALVES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_MB-1:0] hw_set,
  input  logic [NUM_MB-1:0] hw_clr,
  input  logic              sw_wr,
  input  logic [SEL_W-1:0]  sw_sel,
  input  logic [HALF_W-1:0] sw_data,
  output logic [NUM_MB-1:0] flags
);

  logic [NUM_MB-1:0] lane_en;
  logic [NUM_MB-1:0] sw_bits;
  logic [NUM_MB-1:0] sw_set;
  logic [NUM_MB-1:0] sw_clr;
  logic [NUM_MB-1:0] flags_nxt;

  for (genvar h = 0; h < HALVES; h++) begin : g_lane
    assign lane_en[h*HALF_W +: HALF_W] = {HALF_W{sw_wr && (sw_sel == SEL_W'(h))}};
  end
  assign sw_bits = lane_en & {HALVES{sw_data}};

  if (KIND == FLAG_SW_SET) begin : g_sw_set
    assign sw_set = sw_bits;
    assign sw_clr = '0;
  end else if (KIND == FLAG_PLAIN) begin : g_plain
    assign sw_set = sw_bits;
    assign sw_clr = lane_en;
  end else begin : g_hw_set
    assign sw_set = '0;
    assign sw_clr = sw_bits;
  end

  // Sets are applied after clears: a set always wins
  assign flags_nxt = (flags & ~hw_clr & ~sw_clr) | hw_set | sw_set;

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= flags_nxt;
  end

  a_r11_reset_clear: assert property (@(posedge clk) rst |=> (flags == '0));

  a_r8_hw_set_kept: assert property (@(posedge clk) disable iff (rst)
    (hw_set != '0) |=> ((flags & $past(hw_set)) == $past(hw_set)));

  a_r8_sw_set_kept: assert property (@(posedge clk) disable iff (rst)
    (sw_set != '0) |=> ((flags & $past(sw_set)) == $past(sw_set)));

  a_r2_no_spurious_drop: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(flags) & ~$past(hw_clr) & ~$past(sw_clr)) & ~flags) == '0));

endmodule

// File: rtl/can_mbox_irq_ctrl.sv
module can_mbox_irq_ctrl
  import can_mbox_status_pkg::*;
#(
  parameter int unsigned NUM_MB = 32,
  localparam int unsigned IDX_W = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_MB-1:0] mask,
  input  logic              rxdata_ev,
  input  logic [IDX_W-1:0]  rxdata_mb,
  input  logic              remote_ev,
  input  logic [IDX_W-1:0]  remote_mb,
  input  logic              overrun_ev,
  input  logic [IDX_W-1:0]  overrun_mb,
  input  logic              txdone_ev,
  input  logic [IDX_W-1:0]  txdone_mb,
  input  logic              txabort_ev,
  input  logic [IDX_W-1:0]  txabort_mb,
  input  logic              clr_wr,
  input  logic [IRQ_W-1:0]  clr_data,
  output logic [IRQ_W-1:0]  flags,
  output logic              irq_o
);

  // Named request events, gated by the mask held before the edge
  logic rxdata_req, remote_req, overrun_req, empty_req;
  logic [IRQ_W-1:0] set_vec, clr_vec, flags_nxt;

  assign rxdata_req  = rxdata_ev  && !mask[rxdata_mb];
  assign remote_req  = remote_ev  && !mask[remote_mb];
  assign overrun_req = overrun_ev && !mask[overrun_mb];
  assign empty_req   = (txdone_ev && !mask[txdone_mb]) ||
                       (txabort_ev && !mask[txabort_mb]);

  always_comb begin
    set_vec = '0;
    set_vec[IRQ_RXDATA] = rxdata_req;
    set_vec[IRQ_RMT]    = remote_req;
    set_vec[IRQ_EMPTY]  = empty_req;
    set_vec[IRQ_OVR]    = overrun_req;
  end

  assign clr_vec   = clr_wr ? (clr_data & IRQ_IMPL) : '0;
  assign flags_nxt = ((flags & ~clr_vec) | set_vec) & IRQ_IMPL;

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= flags_nxt;
  end

  assign irq_o = |flags;

  a_r4_masked_rxdata: assert property (@(posedge clk) disable iff (rst)
    (rxdata_ev && mask[rxdata_mb]) |=> !$rose(flags[IRQ_RXDATA]));

  a_r4_masked_remote: assert property (@(posedge clk) disable iff (rst)
    (remote_ev && mask[remote_mb]) |=> !$rose(flags[IRQ_RMT]));

  a_r4_masked_overrun: assert property (@(posedge clk) disable iff (rst)
    (overrun_ev && mask[overrun_mb]) |=> !$rose(flags[IRQ_OVR]));

  a_r5_empty_raised: assert property (@(posedge clk) disable iff (rst)
    (txdone_ev && !mask[txdone_mb]) |=> flags[IRQ_EMPTY]);

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(flags) & ~$past(clr_vec)) & ~flags) == '0));

endmodule

// File: rtl/can_mbox_rd_mux.sv
module can_mbox_rd_mux
  import can_mbox_status_pkg::*;
#(
  parameter int unsigned NUM_MB = 32,
  parameter int unsigned HALF_W = 16,
  localparam int unsigned HALVES = NUM_MB / HALF_W,
  localparam int unsigned SEL_W  = (HALVES > 1) ? $clog2(HALVES) : 1,
  localparam int unsigned ADDR_W = CODE_W + SEL_W
) (
  input  logic [NUM_BANKS-1:0][NUM_MB-1:0] bank_flags,
  input  logic [IRQ_W-1:0]                 irq_flags,
  input  logic [ADDR_W-1:0]                rd_addr,
  output logic [HALF_W-1:0]                rd_data
);

  logic [CODE_W-1:0] code;
  logic [SEL_W-1:0]  sel;

  assign code = rd_addr[ADDR_W-1 -: CODE_W];
  assign sel  = rd_addr[SEL_W-1:0];

  always_comb begin
    rd_data = '0;
    if (int'(sel) < HALVES) begin
      if (int'(code) < NUM_BANKS)
        rd_data = bank_flags[code][int'(sel)*HALF_W +: HALF_W];
      else if (int'(code) == C_IRQ && sel == '0)
        rd_data = HALF_W'(irq_flags);
    end
  end

endmodule

// File: rtl/can_mbox_status.sv
module can_mbox_status
  import can_mbox_status_pkg::*;
#(
  parameter int unsigned NUM_MB = 32,
  parameter int unsigned HALF_W = 16,
  localparam int unsigned IDX_W  = $clog2(NUM_MB),
  localparam int unsigned HALVES = NUM_MB / HALF_W,
  localparam int unsigned SEL_W  = (HALVES > 1) ? $clog2(HALVES) : 1,
  localparam int unsigned ADDR_W = CODE_W + SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_rxdata,
  input  logic [IDX_W-1:0]  ev_rxdata_mb,
  input  logic              ev_remote,
  input  logic [IDX_W-1:0]  ev_remote_mb,
  input  logic              ev_overrun,
  input  logic [IDX_W-1:0]  ev_overrun_mb,
  input  logic              ev_txdone,
  input  logic [IDX_W-1:0]  ev_txdone_mb,
  input  logic              ev_txabort,
  input  logic [IDX_W-1:0]  ev_txabort_mb,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [HALF_W-1:0] rd_data,
  output logic [IRQ_W-1:0]  irq_flags,
  output logic              irq_o
);

  function automatic logic [NUM_MB-1:0] mb_onehot(logic en, logic [IDX_W-1:0] idx);
    logic [NUM_MB-1:0] v;
    v = '0;
    if (en) v[idx] = 1'b1;
    return v;
  endfunction

  logic [CODE_W-1:0] wr_code;
  logic [SEL_W-1:0]  wr_sel;
  assign wr_code = wr_addr[ADDR_W-1 -: CODE_W];
  assign wr_sel  = wr_addr[SEL_W-1:0];

  // Named per-mailbox event vectors
  logic [NUM_MB-1:0] rxdata_vec, remote_vec, overrun_vec, txdone_vec, txabort_vec, tx_end_vec;
  assign rxdata_vec  = mb_onehot(ev_rxdata,  ev_rxdata_mb);
  assign remote_vec  = mb_onehot(ev_remote,  ev_remote_mb);
  assign overrun_vec = mb_onehot(ev_overrun, ev_overrun_mb);
  assign txdone_vec  = mb_onehot(ev_txdone,  ev_txdone_mb);
  assign txabort_vec = mb_onehot(ev_txabort, ev_txabort_mb);
  assign tx_end_vec  = txdone_vec | txabort_vec;

  logic [NUM_BANKS-1:0][NUM_MB-1:0] hw_set_a, hw_clr_a, flags_a;

  always_comb begin
    hw_set_a = '0;
    hw_clr_a = '0;
    hw_clr_a[C_TXPEND]  = tx_end_vec;
    hw_clr_a[C_TXCAN]   = tx_end_vec;
    hw_set_a[C_TXACK]   = txdone_vec;
    hw_set_a[C_ABACK]   = txabort_vec;
    hw_set_a[C_RXPEND]  = rxdata_vec;
    hw_set_a[C_RMTPEND] = remote_vec;
    hw_set_a[C_UNREAD]  = overrun_vec;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    can_mbox_flag_bank #(
      .NUM_MB (NUM_MB),
      .HALF_W (HALF_W),
      .KIND   (kind_of(b))
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .hw_set  (hw_set_a[b]),
      .hw_clr  (hw_clr_a[b]),
      .sw_wr   (wr_en && (wr_code == CODE_W'(b))),
      .sw_sel  (wr_sel),
      .sw_data (wr_data),
      .flags   (flags_a[b])
    );
  end

  logic irq_clr_wr;
  assign irq_clr_wr = wr_en && (wr_code == CODE_W'(C_IRQ)) && (wr_sel == '0);

  can_mbox_irq_ctrl #(.NUM_MB(NUM_MB)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .mask       (flags_a[C_MASK]),
    .rxdata_ev  (ev_rxdata),
    .rxdata_mb  (ev_rxdata_mb),
    .remote_ev  (ev_remote),
    .remote_mb  (ev_remote_mb),
    .overrun_ev (ev_overrun),
    .overrun_mb (ev_overrun_mb),
    .txdone_ev  (ev_txdone),
    .txdone_mb  (ev_txdone_mb),
    .txabort_ev (ev_txabort),
    .txabort_mb (ev_txabort_mb),
    .clr_wr     (irq_clr_wr),
    .clr_data   (IRQ_W'(wr_data)),
    .flags      (irq_flags),
    .irq_o      (irq_o)
  );

  can_mbox_rd_mux #(.NUM_MB(NUM_MB), .HALF_W(HALF_W)) u_rd (
    .bank_flags (flags_a),
    .irq_flags  (irq_flags),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
  );

  // R5/R6: status follows a transmit end even for a masked mailbox
  a_r5_done_status: assert property (@(posedge clk) disable iff (rst)
    (ev_txdone && !wr_en) |=> (flags_a[C_TXACK][$past(ev_txdone_mb)] &&
                               !flags_a[C_TXPEND][$past(ev_txdone_mb)] &&
                               !flags_a[C_TXCAN][$past(ev_txdone_mb)]));

  a_r6_abort_status: assert property (@(posedge clk) disable iff (rst)
    (ev_txabort && !wr_en) |=> (flags_a[C_ABACK][$past(ev_txabort_mb)] &&
                                !flags_a[C_TXPEND][$past(ev_txabort_mb)] &&
                                !flags_a[C_TXCAN][$past(ev_txabort_mb)]));

  a_r2_remote_sets: assert property (@(posedge clk) disable iff (rst)
    ev_remote |=> flags_a[C_RMTPEND][$past(ev_remote_mb)]);

  a_r3_rxdata_sets: assert property (@(posedge clk) disable iff (rst)
    ev_rxdata |=> flags_a[C_RXPEND][$past(ev_rxdata_mb)]);

  a_r3_overrun_sets: assert property (@(posedge clk) disable iff (rst)
    ev_overrun |=> flags_a[C_UNREAD][$past(ev_overrun_mb)]);

  a_r12_mask_holds: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_code == CODE_W'(C_MASK)) |=> $stable(flags_a[C_MASK]));

endmodule

// File: tb/can_mbox_status_tb.sv
`timescale 1ns/1ps
module can_mbox_status_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        ev_rxdata = 0, ev_remote = 0, ev_overrun = 0, ev_txdone = 0, ev_txabort = 0;
  logic [4:0]  ev_rxdata_mb = 0, ev_remote_mb = 0, ev_overrun_mb = 0, ev_txdone_mb = 0, ev_txabort_mb = 0;
  logic        wr_en = 0;
  logic [4:0]  wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data, irq_flags;
  logic        irq_o;

  can_mbox_status u_dut (.*);

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  // Bench model: per-code 32-bit registers and interrupt flags
  logic [31:0] m [0:7];
  logic [15:0] mi;

  function automatic logic [31:0] bit_of(logic en, logic [4:0] i);
    return en ? (32'd1 << i) : 32'd0;
  endfunction

  function automatic string req_of(int code);
    case (code)
      0, 1: return "R7";
      2: return "R5";
      3: return "R6";
      4, 6: return "R3";
      5: return "R2";
      7: return "R12";
      8: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [31:0] wl, we, done, ab, oldmask;
    logic [15:0] sets, clr;
    int code;
    code = int'(wr_addr[4:1]);
    wl = 0; we = 0;
    if (wr_en) begin
      we = wr_addr[0] ? 32'hFFFF_0000 : 32'h0000_FFFF;
      wl = wr_addr[0] ? {wr_data, 16'h0} : {16'h0, wr_data};
    end
    done = bit_of(ev_txdone, ev_txdone_mb);
    ab   = bit_of(ev_txabort, ev_txabort_mb);
    oldmask = m[7];
    for (int c = 0; c < 2; c++)
      m[c] = (m[c] & ~(done | ab)) | ((code == c) ? wl : 32'd0);
    m[2] = (m[2] & ~((code == 2) ? wl : 32'd0)) | done;
    m[3] = (m[3] & ~((code == 3) ? wl : 32'd0)) | ab;
    m[4] = (m[4] & ~((code == 4) ? wl : 32'd0)) | bit_of(ev_rxdata, ev_rxdata_mb);
    m[5] = (m[5] & ~((code == 5) ? wl : 32'd0)) | bit_of(ev_remote, ev_remote_mb);
    m[6] = (m[6] & ~((code == 6) ? wl : 32'd0)) | bit_of(ev_overrun, ev_overrun_mb);
    if (code == 7) m[7] = (m[7] & ~we) | wl;
    sets = 0;
    sets[1] = ev_rxdata  && !oldmask[ev_rxdata_mb];
    sets[2] = ev_remote  && !oldmask[ev_remote_mb];
    sets[9] = ev_overrun && !oldmask[ev_overrun_mb];
    sets[8] = (ev_txdone && !oldmask[ev_txdone_mb]) || (ev_txabort && !oldmask[ev_txabort_mb]);
    clr = (wr_en && wr_addr == 5'd16) ? wr_data : 16'h0;
    mi = ((mi & ~clr) | sets) & 16'h0306;
  endtask

  task automatic check_all();
    logic [15:0] exp;
    for (int a = 0; a < 32; a++) begin
      rd_addr = 5'(a);
      #0.1;
      if (a < 16) exp = a[0] ? m[a >> 1][31:16] : m[a >> 1][15:0];
      else if (a == 16) exp = mi;
      else exp = 16'h0;
      check(req_of(a >> 1), rd_data, exp, $sformatf("read addr %0d", a));
    end
    check("R9", irq_flags, mi, "irq_flags");
    check("R10", {15'h0, irq_o}, {15'h0, (mi != 0)}, "irq_o");
  endtask

  task automatic idle_inputs();
    ev_rxdata = 0; ev_remote = 0; ev_overrun = 0; ev_txdone = 0; ev_txabort = 0;
    wr_en = 0;
  endtask

  // Drive at the falling edge, update the model at the rising edge, compare after it
  task automatic cycle();
    @(posedge clk);
    model_step();
    #1;
    check_all();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic wr(logic [3:0] code, logic half, logic [15:0] d);
    wr_en = 1; wr_addr = {code, half}; wr_data = d;
  endtask

  function automatic logic [4:0] pick_mb();
    case ($urandom % 8)
      0: return 5'd0;
      1: return 5'd15;
      2: return 5'd16;
      3: return 5'd31;
      default: return 5'($urandom % 32);
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 8; c++) m[c] = 0;
    mi = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    check_all();  // R11: every register reads 0 after reset

    // R1: mailbox 16 is bit 0 of half 1, mailbox 15 is bit 15 of half 0
    @(negedge clk); ev_remote = 1; ev_remote_mb = 5'd16; cycle();
    rd_addr = {4'd5, 1'b1}; #0.1; check("R1", rd_data, 16'h0001, "mb16 in upper half");
    ev_remote = 1; ev_remote_mb = 5'd15; cycle();
    rd_addr = {4'd5, 1'b0}; #0.1; check("R1", rd_data, 16'h8000, "mb15 in lower half");

    // R2: writing 0 keeps, writing 1 clears
    wr(4'd5, 1'b0, 16'h0000); cycle();
    rd_addr = {4'd5, 1'b0}; #0.1; check("R2", rd_data, 16'h8000, "write 0 keeps");
    wr(4'd5, 1'b0, 16'h8000); cycle();
    rd_addr = {4'd5, 1'b0}; #0.1; check("R2", rd_data, 16'h0000, "write 1 clears");
    wr(4'd8, 1'b0, 16'hFFFF); cycle();

    // R4: masked receive event sets status but no interrupt; R9: unmasking raises nothing
    wr(4'd7, 1'b0, 16'h0008); cycle();
    ev_rxdata = 1; ev_rxdata_mb = 5'd3; cycle();
    check("R4", irq_flags, 16'h0000, "masked rx no irq");
    rd_addr = {4'd4, 1'b0}; #0.1; check("R4", rd_data, 16'h0008, "masked rx status set");
    wr(4'd7, 1'b0, 16'h0000); cycle();
    check("R9", irq_flags, 16'h0000, "unmask raises nothing");

    // R8: event and write-1 clear on the same flag, set wins
    ev_remote = 1; ev_remote_mb = 5'd5; wr(4'd5, 1'b0, 16'h0020); cycle();
    rd_addr = {4'd5, 1'b0}; #0.1; check("R8", rd_data, 16'h0020, "event beats clear");
    // R8: software set beats a hardware clear on transmit-pending
    ev_txdone = 1; ev_txdone_mb = 5'd2; wr(4'd0, 1'b0, 16'h0004); cycle();
    rd_addr = {4'd0, 1'b0}; #0.1; check("R8", rd_data, 16'h0004, "sw set beats hw clear");
    wr(4'd8, 1'b0, 16'hFFFF); cycle();

    // R5: masked mailbox 20 completes: pending/cancel cleared, ack set, no bit 8
    wr(4'd0, 1'b1, 16'h0010); cycle();
    wr(4'd1, 1'b1, 16'h0010); cycle();
    wr(4'd7, 1'b1, 16'h0010); cycle();
    ev_txdone = 1; ev_txdone_mb = 5'd20; cycle();
    rd_addr = {4'd0, 1'b1}; #0.1; check("R5", rd_data, 16'h0000, "pending cleared");
    rd_addr = {4'd1, 1'b1}; #0.1; check("R5", rd_data, 16'h0000, "cancel cleared");
    rd_addr = {4'd2, 1'b1}; #0.1; check("R5", rd_data, 16'h0010, "ack set");
    check("R5", irq_flags, 16'h0000, "masked no empty irq");
    // R6: unmasked abort on mailbox 31 raises bit 8 and the line (R10)
    wr(4'd0, 1'b1, 16'h8000); cycle();
    ev_txabort = 1; ev_txabort_mb = 5'd31; cycle();
    rd_addr = {4'd3, 1'b1}; #0.1; check("R6", rd_data, 16'h8000, "abort ack set");
    check("R6", irq_flags, 16'h0100, "empty irq set");
    check("R10", {15'h0, irq_o}, 16'h0001, "line high");

    // Constrained random phase
    for (int i = 0; i < 600; i++) begin
      ev_rxdata  = ($urandom % 4) == 0; ev_rxdata_mb  = pick_mb();
      ev_remote  = ($urandom % 4) == 0; ev_remote_mb  = pick_mb();
      ev_overrun = ($urandom % 5) == 0; ev_overrun_mb = pick_mb();
      ev_txdone  = ($urandom % 4) == 0; ev_txdone_mb  = pick_mb();
      ev_txabort = ($urandom % 6) == 0; ev_txabort_mb = pick_mb();
      if (($urandom % 2) == 0) begin
        wr_en = 1;
        wr_addr = 5'($urandom % 32);
        wr_data = (($urandom % 3) == 0) ? 16'hFFFF : 16'($urandom);
      end
      cycle();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule